// File: doc/BRIEF.md
# Least-Frequently-Used Victim Selector with Count Decay

This block tracks replacement state for one set of an N-way cache. Each way holds a valid bit, a saturating use count and a fill-order rank. The surrounding cache controller reports every lookup with an access strobe and a hit flag. On a hit it also gives the way that matched. On a miss the block names the way to refill and updates its own state for that way in the same clock edge.

The way to refill is an empty way if the set has one, with the lowest index first. Once the set is full, it is the way with the smallest use count. When several ways share that count, the way filled longest ago is chosen. A separate decay pulse halves every valid count, with a floor of one. A block that was once popular therefore loses its protection over time and can be evicted again.

Top module: `lfu_victim_sel`

## Requirements
- R1: After reset every way is empty, `victim_way` reads 0 and `victim_vld` is low while no access is presented.
- R2: `victim_vld` is high exactly in cycles where `acc_vld` is 1 and `acc_hit` is 0, and the registered state then fills `victim_way`.
- R3: While any way is empty, `victim_way` names the lowest-indexed empty way.
- R4: A fill marks the way valid with a use count of 1 and makes it the most recently filled way. A way stays valid until reset.
- R5: A hit increments the use count of `hit_way`. A hit naming an empty way changes nothing, and that way is still offered as the victim.
- R6: With the set full, `victim_way` holds the smallest use count. Among ways tied at that count, it names the one filled earliest. On three ways, the trace A,B,C,A,D,B,E,A gives exactly 2 hits and A is never evicted.
- R7: Use counts saturate at 2^CNT_W-1 instead of wrapping.
- R8: A cycle with `age_pulse` high shifts each valid way's count right by one bit. A valid way whose count would become 0 keeps a count of 1.
- R9: When a hit and `age_pulse` occur in the same cycle, the count is halved first and then incremented.
- R10: Without decay pulses, a way with a much higher count is never evicted. On three ways, X accessed five times followed by Y,Z,W repeated twice misses on all 6 loop accesses and keeps X. After enough decay pulses, X becomes the victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | A lookup on this set happens this cycle |
| acc_hit | input | 1 | The lookup matched a resident way |
| hit_way | input | WAY_W | Way that matched, meaningful when `acc_hit` is 1 |
| age_pulse | input | 1 | Halve all valid use counts this cycle |
| victim_way | output | WAY_W | Way to refill on a miss |
| victim_vld | output | 1 | A miss is consuming `victim_way` this cycle |

## Verification
The bound checker enforces the per-cycle invariants on every cycle. These are: empty ways are preferred, the victim never has a larger count than any full-set peer, valid ways never hold a zero count, saturated counts hold, a fill loads a count of one, and valid bits never drop. Whole-trace outcomes can only be shown by the bench scenarios, because they depend on a history of several cycles. Examples are the hit total of the three-way trace, the permanent residency of a heavily used way, its eviction after decay, the fill-order tie-break, and the ordering of decay and increment in one cycle.

// File: rtl/lfu_pkg.sv
package lfu_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_HIT  = 2'd1,
        OP_FILL = 2'd2
    } lfu_op_e;

    function automatic lfu_op_e lfu_decode(input logic vld, input logic hit);
        if (!vld) return OP_NONE;
        return hit ? OP_HIT : OP_FILL;
    endfunction

endpackage

// File: rtl/lfu_cnt_next.sv
module lfu_cnt_next #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             vld_q,
    input  logic             age,
    input  logic             inc,
    input  logic             fill,
    output logic [CNT_W-1:0] cnt_d
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] aged;

    always_comb begin
        aged = cnt_q;
        if (age && vld_q) begin
            aged = cnt_q >> 1;
            if (aged == '0) aged = CNT_ONE;
        end
        cnt_d = aged;
        if (fill) begin
            cnt_d = CNT_ONE;
        end else if (!vld_q) begin
            cnt_d = '0;
        end else if (inc && aged != CNT_MAX) begin
            cnt_d = aged + CNT_ONE;
        end
    end
endmodule

// File: rtl/lfu_victim_pick.sv
module lfu_victim_pick #(
    parameter int WAYS  = 4,
    parameter int CNT_W = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][CNT_W-1:0]  cnt,
    input  logic [WAYS-1:0][WAY_W-1:0]  rank,
    output logic [WAY_W-1:0]            victim
);
    logic             have_free;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] best;

    always_comb begin
        have_free = 1'b0;
        free_way  = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                have_free = 1'b1;
                free_way  = WAY_W'(i);
            end
        end
    end

    always_comb begin
        best = '0;
        for (int i = 1; i < WAYS; i++) begin
            if ((cnt[i] < cnt[best]) ||
                ((cnt[i] == cnt[best]) && (rank[i] > rank[best]))) begin
                best = WAY_W'(i);
            end
        end
    end

    assign victim = have_free ? free_way : best;
endmodule

// File: rtl/lfu_victim_sel.sv
module lfu_victim_sel
    import lfu_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int CNT_W = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_vld,
    input  logic             acc_hit,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             age_pulse,
    output logic [WAY_W-1:0] victim_way,
    output logic             victim_vld
);
    typedef struct packed {
        logic [WAYS-1:0]             vld;
        logic [WAYS-1:0][CNT_W-1:0]  cnt;
        logic [WAYS-1:0][WAY_W-1:0]  rank;
    } set_state_t;

    set_state_t st_d, st_q;

    logic [WAYS-1:0]            vld_q;
    logic [WAYS-1:0][CNT_W-1:0] cnt_q;
    logic [WAYS-1:0][WAY_W-1:0] rank_q;
    logic [WAYS-1:0][CNT_W-1:0] cnt_nx;
    logic [WAY_W-1:0]           pick_way;
    lfu_op_e                    op;

    assign vld_q  = st_q.vld;
    assign cnt_q  = st_q.cnt;
    assign rank_q = st_q.rank;
    assign op     = lfu_decode(acc_vld, acc_hit);

    lfu_victim_pick #(.WAYS(WAYS), .CNT_W(CNT_W)) u_pick (
        .vld    (vld_q),
        .cnt    (cnt_q),
        .rank   (rank_q),
        .victim (pick_way)
    );

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        lfu_cnt_next #(.CNT_W(CNT_W)) u_cnt (
            .cnt_q (cnt_q[g]),
            .vld_q (vld_q[g]),
            .age   (age_pulse),
            .inc   ((op == OP_HIT)  && (hit_way  == WAY_W'(g))),
            .fill  ((op == OP_FILL) && (pick_way == WAY_W'(g))),
            .cnt_d (cnt_nx[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_nx;
        if (op == OP_FILL) begin
            for (int i = 0; i < WAYS; i++) begin
                if ((WAY_W'(i) != pick_way) && vld_q[i] &&
                    (!vld_q[pick_way] || (rank_q[i] < rank_q[pick_way]))) begin
                    st_d.rank[i] = rank_q[i] + WAY_W'(1);
                end
            end
            st_d.rank[pick_way] = '0;
            st_d.vld[pick_way]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign victim_way = pick_way;
    assign victim_vld = (op == OP_FILL);
endmodule

// File: rtl/lfu_victim_sel_chk.sv
module lfu_victim_sel_chk #(
    parameter int WAYS  = 4,
    parameter int CNT_W = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      acc_vld,
    input logic                      acc_hit,
    input logic [WAY_W-1:0]          hit_way,
    input logic                      age_pulse,
    input logic [WAY_W-1:0]          victim_way,
    input logic                      victim_vld,
    input logic [WAYS-1:0]           vld_q,
    input logic [WAYS-1:0][CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             prev_fill;
    logic [WAY_W-1:0] prev_vic;
    logic             prev_sat;
    logic [WAY_W-1:0] prev_hw;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_fill <= 1'b0;
            prev_vic  <= '0;
            prev_sat  <= 1'b0;
            prev_hw   <= '0;
        end else begin
            prev_fill <= victim_vld;
            prev_vic  <= victim_way;
            prev_sat  <= acc_vld && acc_hit && !age_pulse && vld_q[hit_way] &&
                         (cnt_q[hit_way] == CNT_MAX);
            prev_hw   <= hit_way;
        end
    end

    assert_vld_on_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
        victim_vld |-> (acc_vld && !acc_hit));

    assert_free_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&vld_q)) |-> !vld_q[victim_way]);

    assert_fill_loads_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prev_fill |-> (vld_q[prev_vic] && (cnt_q[prev_vic] == CNT_W'(1))));

    assert_sat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prev_sat |-> (cnt_q[prev_hw] == CNT_MAX));

    for (genvar g = 0; g < WAYS; g++) begin : g_chk
        assert_sticky_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
            vld_q[g] |=> vld_q[g]);

        assert_floor_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
            vld_q[g] |-> (cnt_q[g] != '0));

        assert_min_victim_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (&vld_q) |-> (cnt_q[victim_way] <= cnt_q[g]));
    end
endmodule

bind lfu_victim_sel lfu_victim_sel_chk #(.WAYS(WAYS), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_vld    (acc_vld),
    .acc_hit    (acc_hit),
    .hit_way    (hit_way),
    .age_pulse  (age_pulse),
    .victim_way (victim_way),
    .victim_vld (victim_vld),
    .vld_q      (vld_q),
    .cnt_q      (cnt_q)
);

// File: tb/sim_lfu_victim_sel.sv
module sim_lfu_victim_sel;
    localparam int WAYS  = 3;
    localparam int CNT_W = 4;
    localparam int WAY_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_vld = 1'b0;
    logic             acc_hit = 1'b0;
    logic [WAY_W-1:0] hit_way = '0;
    logic             age_pulse = 1'b0;
    logic [WAY_W-1:0] victim_way;
    logic             victim_vld;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    int tags [WAYS];
    bit tval [WAYS];
    int hits;
    int misses;

    always #5 clk = ~clk;

    lfu_victim_sel #(.WAYS(WAYS), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_hit(acc_hit),
        .hit_way(hit_way), .age_pulse(age_pulse),
        .victim_way(victim_way), .victim_vld(victim_vld)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; acc_vld = 1'b0; acc_hit = 1'b0; age_pulse = 1'b0;
        @(posedge clk); @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < WAYS; i++) begin tval[i] = 0; tags[i] = 0; end
        hits = 0; misses = 0;
    endtask

    // one cycle of lookup; victim and flag are sampled before the edge
    task automatic op(input bit hit, input int way, input bit age,
                      output int vic, output bit vv);
        @(negedge clk);
        acc_vld = 1'b1; acc_hit = hit; hit_way = WAY_W'(way); age_pulse = age;
        #1;
        vic = int'(victim_way); vv = victim_vld;
        @(posedge clk);
        #1;
        acc_vld = 1'b0; acc_hit = 1'b0; age_pulse = 1'b0;
    endtask

    task automatic age_only();
        @(negedge clk);
        age_pulse = 1'b1;
        @(posedge clk);
        #1 age_pulse = 1'b0;
    endtask

    task automatic peek(output int vic);
        @(negedge clk);
        vic = int'(victim_way);
    endtask

    task automatic hit_n(input int way, input int n);
        int v; bit vv;
        for (int i = 0; i < n; i++) op(1, way, 0, v, vv);
    endtask

    task automatic touch(input int tag);
        int v; bit vv; int w;
        w = -1;
        for (int i = 0; i < WAYS; i++) if (tval[i] && tags[i] == tag) w = i;
        if (w >= 0) begin
            op(1, w, 0, v, vv);
            hits++;
        end else begin
            op(0, 0, 0, v, vv);
            tags[v] = tag; tval[v] = 1;
            misses++;
        end
    endtask

    function automatic bit resident(input int tag);
        for (int i = 0; i < WAYS; i++) if (tval[i] && tags[i] == tag) return 1;
        return 0;
    endfunction

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check(victim_way == 0, "R1 victim after reset", int'(victim_way), 0);
        check(victim_vld == 0, "R1 flag after reset", int'(victim_vld), 0);
    endtask

    task automatic t_fill_order();
        int v; bit vv;
        do_reset();
        for (int i = 0; i < WAYS; i++) begin
            op(0, 0, 0, v, vv);
            check(v == i, "R3 empty ways filled lowest first", v, i);
            check(vv == 1, "R2 flag on miss", int'(vv), 1);
        end
        op(1, 1, 0, v, vv);
        check(vv == 0, "R2 flag low on hit", int'(vv), 0);
        peek(v);
        check(v == 0, "R6 tie goes to earliest fill", v, 0);
    endtask

    task automatic t_invalid_hit();
        int v; bit vv;
        do_reset();
        op(0, 0, 0, v, vv);
        hit_n(2, 3);
        hit_n(1, 2);
        peek(v);
        check(v == 1, "R5 hit on empty way ignored", v, 1);
        op(0, 0, 0, v, vv);
        check(v == 1, "R5 empty way still refilled", v, 1);
    endtask

    task automatic t_trace();
        do_reset();
        touch(1); touch(2); touch(3); touch(1);
        touch(4); touch(2); touch(5); touch(1);
        check(hits == 2, "R6 three-way trace hit count", hits, 2);
        check(resident(1), "R6 A stays resident", int'(resident(1)), 1);
    endtask

    task automatic t_pollution();
        int v;
        int m0;
        do_reset();
        for (int i = 0; i < 5; i++) touch(10);
        m0 = misses;
        for (int r = 0; r < 2; r++) begin touch(11); touch(12); touch(13); end
        check(misses - m0 == 6, "R10 loop misses without decay", misses - m0, 6);
        check(resident(10), "R10 popular way kept", int'(resident(10)), 1);
        peek(v);
        check(v != 0, "R10 popular way not victim", v, 1);
        age_only();
        age_only();
        peek(v);
        check(v == 0, "R10 decayed way becomes victim", v, 0);
    endtask

    task automatic t_saturate();
        int v; bit vv;
        do_reset();
        for (int i = 0; i < WAYS; i++) op(0, 0, 0, v, vv);
        hit_n(0, 20);
        hit_n(1, 14);
        hit_n(2, 13);
        peek(v);
        check(v == 2, "R7 saturated count does not wrap", v, 2);
        hit_n(2, 1);
        peek(v);
        check(v == 0, "R7 all saturated, earliest fill", v, 0);
    endtask

    task automatic t_age_floor();
        int v; bit vv;
        do_reset();
        for (int i = 0; i < WAYS; i++) op(0, 0, 0, v, vv);
        op(0, 0, 0, v, vv);
        check(v == 0, "R6 full set ties to oldest", v, 0);
        hit_n(1, 1);
        hit_n(2, 1);
        age_only();
        peek(v);
        check(v == 1, "R8 count of one floors at one", v, 1);
    endtask

    task automatic t_age_hit_order();
        int v; bit vv;
        do_reset();
        for (int i = 0; i < WAYS; i++) op(0, 0, 0, v, vv);
        hit_n(0, 3);
        hit_n(1, 4);
        hit_n(2, 4);
        op(1, 0, 1, v, vv);
        peek(v);
        check(v == 1, "R9 decay applied before increment", v, 1);
    endtask

    initial begin
        t_reset();
        t_fill_order();
        t_invalid_hit();
        t_trace();
        t_pollution();
        t_saturate();
        t_age_floor();
        t_age_hit_order();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule